// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block evaluates one integer operation per clock on two operand words. The datapath is a chain of identical one-bit cells. Each cell carries AND, OR and full-adder paths and a per-bit "less" input, and a two-bit path select picks one of them. The carry ripples from cell to cell. A three-bit operation code steers the whole chain. Its upper bit inverts operand b and also feeds the carry into bit 0, which turns the adder into a subtractor. Its lower two bits choose the path.

Set-on-less-than reuses the subtraction. The sign of a − b is corrected by the overflow of that subtraction, so the signed comparison stays right when the difference does not fit in the word. The corrected bit drives the less input of bit 0, and every other less input is held low.

The result, a zero flag and a signed-overflow flag are captured in output registers one clock after the operands. An integer pipeline can place the block directly in its execute stage and use the zero flag to test for equality.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next register state is `result_o` = 0, `zero_o` = 1 and `ovf_o` = 0.
- R2: Outputs are registered. They change only at a rising clock edge and reflect the `op_i`, `a_i` and `b_i` values sampled at that edge.
- R3: Code 3'b000 gives the bitwise AND of a and b. Code 3'b001 gives the bitwise OR of a and b.
- R4: Code 3'b010 gives a + b modulo 2^W.
- R5: Code 3'b110 gives a − b modulo 2^W, computed as a plus the inverse of b with a carry of 1 into bit 0.
- R6: Code 3'b111 gives 1 in bit 0 when a < b as signed numbers, and 0 otherwise. Bits W-1..1 are 0. The answer is also right when a − b overflows, for example 0x80000000 versus 1.
- R7: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R8: For codes 3'b010 and 3'b110, `ovf_o` equals the carry into the top bit XOR the carry out of the top bit. Two cases show it: 0x7FFFFFFF + 1 sets the flag, and 0x80000000 − 1 sets the flag.
- R9: For codes 3'b000, 3'b001 and 3'b111, `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code: bit 2 inverts b and sets carry-in, bits 1:0 select the path |
| a_i | input | W (32) | Operand a |
| b_i | input | W (32) | Operand b |
| result_o | output | W (32) | Registered result |
| zero_o | output | 1 | Registered flag, high when the result is all zeros |
| ovf_o | output | 1 | Registered signed-overflow flag for add and subtract |

## Verification
A broken carry link between two cells corrupts every add and subtract whose carry crosses that link. The error shows in the upper result bits on the very next clock after the operands are applied. A wrong overflow tap or a wrong sign correction leaves ordinary operands alone. It only shows on operands that sit at the signed range ends, which is why the directed cases push 0x7FFFFFFF and 0x80000000 through add, subtract and set-less-than. Because all outputs are registered with one cycle of latency, any such fault is visible in the cycle right after the operation is presented.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  // Operation codes: bit 2 inverts b and provides carry-in; bits 1:0 pick the path.
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Path select inside one bit cell.
  typedef enum logic [1:0] {
    PATH_AND  = 2'b00,
    PATH_OR   = 2'b01,
    PATH_SUM  = 2'b10,
    PATH_LESS = 2'b11
  } cell_path_e;
endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import int_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       less_i,
  input  logic       cin_i,
  input  logic [1:0] path_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       sum_o
);
  logic a_eff, b_eff;

  always_comb begin
    a_eff  = a_i ^ inv_a_i;
    b_eff  = b_i ^ inv_b_i;
    sum_o  = a_eff ^ b_eff ^ cin_i;
    cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);
    unique case (cell_path_e'(path_i))
      PATH_AND:  res_o = a_eff & b_eff;
      PATH_OR:   res_o = a_eff | b_eff;
      PATH_SUM:  res_o = sum_o;
      PATH_LESS: res_o = less_i;
      default:   res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cell_chain.sv
module alu_cell_chain #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         cin_msb_o,
  output logic         cout_msb_o
);
  localparam int MSB = W - 1;

  logic inv_b;
  logic set_bit;
  logic [1:0] path;

  assign inv_b = op_i[2];
  assign path  = op_i[1:0];

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic c_in, c_out, r_bit, s_bit, lt_in;

    if (i == 0) begin : g_first
      assign c_in  = inv_b;
      assign lt_in = set_bit;
    end else begin : g_rest
      assign c_in  = g_cell[i-1].c_out;
      assign lt_in = 1'b0;
    end

    alu_bit_cell u_cell (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_a_i (1'b0),
      .inv_b_i (inv_b),
      .less_i  (lt_in),
      .cin_i   (c_in),
      .path_i  (path),
      .res_o   (r_bit),
      .cout_o  (c_out),
      .sum_o   (s_bit)
    );

    assign res_o[i] = r_bit;
  end

  assign cin_msb_o  = g_cell[MSB].c_in;
  assign cout_msb_o = g_cell[MSB].c_out;
  // True sign of a - b: raw sign corrected by the overflow of the subtraction.
  assign set_bit    = g_cell[MSB].s_bit ^ (cin_msb_o ^ cout_msb_o);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [2:0]   op_i,
  input  logic         cin_msb_i,
  input  logic         cout_msb_i,
  output logic         zero_o,
  output logic         ovf_o
);
  logic sum_path;

  assign sum_path = (op_i[1:0] == 2'b10);
  assign zero_o   = ~|res_i;
  assign ovf_o    = sum_path & (cin_msb_i ^ cout_msb_i);
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);
  logic [W-1:0] res_c;
  logic         cin_msb, cout_msb, zero_c, ovf_c;

  alu_cell_chain #(.W(W)) u_chain (
    .a_i        (a_i),
    .b_i        (b_i),
    .op_i       (op_i),
    .res_o      (res_c),
    .cin_msb_o  (cin_msb),
    .cout_msb_o (cout_msb)
  );

  alu_flag_unit #(.W(W)) u_flags (
    .res_i      (res_c),
    .op_i       (op_i),
    .cin_msb_i  (cin_msb),
    .cout_msb_i (cout_msb),
    .zero_o     (zero_c),
    .ovf_o      (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_c;
      zero_o   <= zero_c;
      ovf_o    <= ovf_c;
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         ovf_o
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && zero_o && !ovf_o));

  p_and_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b000) |=> (result_o == ($past(a_i) & $past(b_i))));

  p_add_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b010) |=> (result_o == $past(a_i) + $past(b_i)));

  p_sub_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b110) |=> (result_o == $past(a_i) - $past(b_i)));

  p_slt_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b111) |=>
      (result_o == {{(W-1){1'b0}}, ($signed($past(a_i)) < $signed($past(b_i)))}));

  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  p_add_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b010) |=>
      (ovf_o == (($past(a_i[W-1]) == $past(b_i[W-1])) && (result_o[W-1] != $past(a_i[W-1])))));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b111) |=> !ovf_o);
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op  = 3'b000;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [W-1:0] result;
  logic         zero, ovf;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  int_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Independent reference from the requirements.
  task automatic model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       output logic [W-1:0] r, output logic z, output logic v);
    r = '0; v = 1'b0;
    case (o)
      3'b000: r = x & y;
      3'b001: r = x | y;
      3'b010: begin r = x + y; v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); end
      3'b110: begin r = x - y; v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); end
      3'b111: r = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      default: r = '0;
    endcase
    z = (r == '0);
  endtask

  // Drive at a falling edge, check at the following falling edge.
  task automatic run(input string req, input logic [2:0] o,
                     input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] er;
    logic ez, ev;
    @(negedge clk);
    op = o; a = x; b = y;
    model(o, x, y, er, ez, ev);
    @(negedge clk);
    chk(req, "result", result, er);
    chk(req, "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, ez});
    chk(req, "ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, ev});
  endtask

  task automatic t_reset;
    // R1: reset state
    rst = 1'b1;
    op = 3'b001; a = 32'hFFFF_FFFF; b = 32'h1;
    repeat (3) @(negedge clk);
    chk("R1", "result", result, '0);
    chk("R1", "zero", {31'd0, zero}, 32'd1);
    chk("R1", "ovf", {31'd0, ovf}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    // R2: new inputs do not show before the next rising edge
    run("R2", 3'b010, 32'd5, 32'd6);
    @(negedge clk);
    op = 3'b010; a = 32'd100; b = 32'd1;
    #1;
    chk("R2", "result held", result, 32'd11);
    @(negedge clk);
    chk("R2", "result updated", result, 32'd101);
  endtask

  task automatic t_logic;
    run("R3", 3'b000, 32'hF0F0_1234, 32'h0FF0_FF00);
    run("R3", 3'b001, 32'hF0F0_1234, 32'h0FF0_FF00);
    run("R3", 3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
  endtask

  task automatic t_add;
    run("R4", 3'b010, 32'h1234_5678, 32'h0FED_CBA9);
    run("R4", 3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    run("R8", 3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    run("R8", 3'b010, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub;
    run("R5", 3'b110, 32'd1000, 32'd1);
    run("R5", 3'b110, 32'd3, 32'd7);
    run("R8", 3'b110, 32'h8000_0000, 32'h0000_0001);
    run("R8", 3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_slt;
    run("R6", 3'b111, 32'hFFFF_FFFF, 32'h0);
    run("R6", 3'b111, 32'h0, 32'hFFFF_FFFF);
    run("R6", 3'b111, 32'h8000_0000, 32'h1);
    run("R6", 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run("R6", 3'b111, 32'd42, 32'd42);
  endtask

  task automatic t_zero;
    run("R7", 3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run("R7", 3'b000, 32'hFF00_0000, 32'h00FF_0000);
    run("R7", 3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
  endtask

  task automatic t_no_ovf;
    // R9: operands that would overflow an add still leave the flag low
    run("R9", 3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    run("R9", 3'b001, 32'h8000_0000, 32'h8000_0000);
    run("R9", 3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_zero();
    t_no_ovf();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule